// File: doc/BRIEF.md
# Core Control and Data-Memory Clear Sequencer

This block holds the 16-bit core control word of an audio signal processor and turns it into the controls used to shut the core down, reload it and restart it. Two shutdown bits of opposite polarity hold the accumulators and the serial input and output registers at zero. A ramp-down request bit asks the volume ramp engine to slew every ramped value to zero, and a read-only status bit lets the host poll for the end of that ramp. A mute bit forces all ramp targets to zero until it is cleared. A self-clearing trigger bit starts a walker that writes zero into every data-memory address, one per clock.

The host writes the whole word with `wr_en`, and reads it back on `rd_data` at any time. The memory-clear outputs feed the data memory's write port directly. `ramp_zero` comes from the ramp engine and is high when all ramped values are at zero. At a clock of `CLK_MHZ` the walk of `DEPTH` words must fit in 100 µs. The default of 1024 words at 125 MHz takes 1024 cycles, against a budget of 12500.

Top module: `core_ctrl_seq`

## Requirements
- R1: After reset, `rd_data` is 0x0000, `core_zero` is 1, and `mem_busy`, `mem_we`, `slew_mute` and `ramp_down_req` are 0.
- R2: `core_zero` is 1 whenever bit 9 of the word is 0 (active-low shutdown) or bit 6 is 1 (active-high shutdown), and 0 otherwise.
- R3: Bits 6, 9, 12 and 14 take the value written on the clock edge where `wr_en` is 1 and read back unchanged. Bits 0–5, 8, 10, 11 and 15 always read 0.
- R4: When `wr_en` is 1 with bit 7 set and no clear is running, the next cycle shows `mem_busy` = 1, `mem_we` = 1, `mem_addr` = 0, and bit 7 reads 1.
- R5: During a clear, `mem_addr` rises by one on every clock up to `DEPTH`-1. On the edge after that address, `mem_busy` and bit 7 fall to 0. Each clear therefore lasts exactly `DEPTH` cycles.
- R6: While a clear runs, host writes to bit 7 are ignored, whether they carry 0 or 1. The walk neither restarts nor stops early.
- R7: `slew_mute` follows bit 14. Setting the bit forces all ramp targets to zero, and clearing it restores them.
- R8: `ramp_down_req` follows bit 12. Setting the bit requests a ramp to zero, and clearing it requests the ramp back up.
- R9: Bit 13 goes to 1 on the first clock edge where bit 12, after that edge, is 1 and `ramp_zero` is sampled high. It then stays at 1 while bit 12 remains 1.
- R10: Bit 13 drops to 0 on the same edge where bit 12 is cleared. Host writes to bit 13 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Host write strobe for the control word |
| wr_data | input | 16 | Control word written by the host |
| rd_data | output | 16 | Control word as read by the host, including status bits |
| ramp_zero | input | 1 | Ramp engine reports all ramped values at zero |
| core_zero | output | 1 | Hold accumulators and serial registers at zero |
| slew_mute | output | 1 | Force all ramp targets to zero |
| ramp_down_req | output | 1 | Request a ramp of all ramped values to zero |
| mem_busy | output | 1 | Data-memory clear in progress |
| mem_we | output | 1 | Data-memory write enable for the clear |
| mem_addr | output | $clog2(DEPTH) | Data-memory address being cleared |

## Verification
The bench builds the block with `DEPTH` = 16 and `CLK_MHZ` = 125. With that depth, one clear ends within a few dozen cycles, so a random run covers many complete walks. It also covers many host writes that land on the first, middle and final address of a walk, and restarts issued on the cycle right after a walk ends. The short walk also leaves room for long stretches of ramp-request and ramp-zero toggling. Those stretches test the done bit against every order in which the request, the ramp report and a request removal can arrive.

// File: rtl/core_ctrl_pkg.sv
package core_ctrl_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned B_SHUT_HI = 6;
  localparam int unsigned B_CLEAR   = 7;
  localparam int unsigned B_RUN_N   = 9;
  localparam int unsigned B_RAMP_DN = 12;
  localparam int unsigned B_RAMP_OK = 13;
  localparam int unsigned B_MUTE    = 14;

  typedef struct packed {
    logic mute;
    logic ramp_dn;
    logic run_n;
    logic shut_hi;
  } ctrl_fields_t;
endpackage

// File: rtl/cc_ctrl_reg.sv
module cc_ctrl_reg
  import core_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_fields_t      fields_q,
  output ctrl_fields_t      fields_nxt
);
  ctrl_fields_t from_bus;

  always_comb begin
    from_bus.mute    = wr_data[B_MUTE];
    from_bus.ramp_dn = wr_data[B_RAMP_DN];
    from_bus.run_n   = wr_data[B_RUN_N];
    from_bus.shut_hi = wr_data[B_SHUT_HI];
    fields_nxt = wr_en ? from_bus : fields_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fields_q <= '0;
    else if (wr_en) fields_q <= fields_nxt;
  end

  // R2: with the run bit low after reset, the core stays held until a write
  p_hold_until_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !fields_q.run_n |=> !fields_q.run_n);
endmodule

// File: rtl/cc_clear_walker.sv
module cc_clear_walker #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy_nxt;
  logic [AW-1:0] addr_nxt;
  logic          step_en;

  always_comb begin
    busy_nxt = busy;
    addr_nxt = addr;
    if (busy) begin
      if (addr == LAST) busy_nxt = 1'b0;
      else addr_nxt = addr + AW'(1);
    end else if (start) begin
      busy_nxt = 1'b1;
      addr_nxt = '0;
    end
    step_en = busy | start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (step_en) begin
      busy <= busy_nxt;
      addr <= addr_nxt;
    end
  end

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && addr == '0);
  p_walk_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && addr != LAST |=> busy && addr == $past(addr) + AW'(1));
  p_walk_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && addr == LAST |=> !busy);
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && addr != LAST |=> addr != '0);
endmodule

// File: rtl/cc_ramp_status.sv
module cc_ramp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic req_nxt,
  input  logic req_q,
  input  logic ramp_zero,
  output logic done
);
  logic done_nxt;
  logic upd_en;

  always_comb begin
    done_nxt = req_nxt & (done | ramp_zero);
    upd_en   = done | req_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else if (upd_en) done <= done_nxt;
  end

  p_done_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_q);
  p_done_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> !done);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && req_nxt |=> done);
endmodule

// File: rtl/core_ctrl_seq.sv
module core_ctrl_seq
  import core_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned CLK_MHZ = 125,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ramp_zero,
  output logic              core_zero,
  output logic              slew_mute,
  output logic              ramp_down_req,
  output logic              mem_busy,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr
);
  localparam int unsigned CLEAR_BUDGET = CLK_MHZ * 100;
  localparam bit FITS_BUDGET = (DEPTH <= CLEAR_BUDGET);

  ctrl_fields_t fields_q, fields_nxt;
  logic         clr_start;
  logic         ramp_done;

  cc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fields_q(fields_q), .fields_nxt(fields_nxt)
  );

  assign clr_start = wr_en & wr_data[B_CLEAR];

  cc_clear_walker #(.DEPTH(DEPTH)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(clr_start),
    .busy(mem_busy), .addr(mem_addr)
  );

  cc_ramp_status u_ramp (
    .clk(clk), .rst_n(rst_n), .req_nxt(fields_nxt.ramp_dn),
    .req_q(fields_q.ramp_dn), .ramp_zero(ramp_zero), .done(ramp_done)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[B_SHUT_HI] = fields_q.shut_hi;
    rd_data[B_CLEAR]   = mem_busy;
    rd_data[B_RUN_N]   = fields_q.run_n;
    rd_data[B_RAMP_DN] = fields_q.ramp_dn;
    rd_data[B_RAMP_OK] = ramp_done;
    rd_data[B_MUTE]    = fields_q.mute;
    core_zero     = ~fields_q.run_n | fields_q.shut_hi;
    slew_mute     = fields_q.mute;
    ramp_down_req = fields_q.ramp_dn;
    mem_we        = mem_busy & FITS_BUDGET;
  end

  p_mute_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slew_mute == $past(wr_data[B_MUTE]));
  p_req_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ramp_down_req == $past(wr_data[B_RAMP_DN]));
  p_busy_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_busy) |-> $past(wr_en));
endmodule

// File: tb/sim_core_ctrl_seq.sv
module sim_core_ctrl_seq;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_data = '0;
  logic          ramp_zero = 1'b0;
  logic [15:0]   rd_data;
  logic          core_zero, slew_mute, ramp_down_req, mem_busy, mem_we;
  logic [AW-1:0] mem_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench reference state
  bit m_shut, m_run, m_req, m_mute, m_busy, m_done;
  int m_addr;

  core_ctrl_seq #(.DEPTH(DEPTH), .CLK_MHZ(125)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ramp_zero(ramp_zero), .core_zero(core_zero),
    .slew_mute(slew_mute), .ramp_down_req(ramp_down_req),
    .mem_busy(mem_busy), .mem_we(mem_we), .mem_addr(mem_addr)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_word();
    logic [15:0] w = '0;
    w[6] = m_shut; w[7] = m_busy; w[9] = m_run;
    w[12] = m_req; w[13] = m_done; w[14] = m_mute;
    return w;
  endfunction

  task automatic model_step(input bit we, input logic [15:0] wd, input bit z);
    bit req_n;
    if (m_busy) begin
      if (m_addr == DEPTH - 1) m_busy = 0;
      else m_addr++;
    end else if (we && wd[7]) begin
      m_busy = 1; m_addr = 0;
    end
    req_n = we ? wd[12] : m_req;
    m_done = req_n & (m_done | z);
    if (we) begin
      m_shut = wd[6]; m_run = wd[9]; m_req = wd[12]; m_mute = wd[14];
    end
  endtask

  task automatic compare_all();
    chk("R3 word", int'(rd_data & 16'h5240), int'(exp_word() & 16'h5240));
    chk("R3 reserved", int'(rd_data & 16'h8D3F), 0);
    chk("R5 clear bit", int'(rd_data[7]), int'(m_busy));
    chk("R9 done bit", int'(rd_data[13]), int'(m_done));
    chk("R2 core_zero", int'(core_zero), int'(!m_run || m_shut));
    chk("R7 slew_mute", int'(slew_mute), int'(m_mute));
    chk("R8 ramp_down_req", int'(ramp_down_req), int'(m_req));
    chk("R5 mem_busy", int'(mem_busy), int'(m_busy));
    chk("R4 mem_we", int'(mem_we), int'(m_busy));
    if (m_busy) chk("R5 mem_addr", int'(mem_addr), m_addr);
  endtask

  // called at a negedge: drive, take one edge, compare at next negedge
  task automatic cyc(input bit we, input logic [15:0] wd, input bit z);
    wr_en = we; wr_data = wd; ramp_zero = z;
    @(posedge clk);
    model_step(we, wd, z);
    @(negedge clk);
    wr_en = 1'b0;
    compare_all();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_shut = 0; m_run = 0; m_req = 0; m_mute = 0; m_busy = 0; m_done = 0; m_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 core_zero", int'(core_zero), 1);
    chk("R1 mem_busy", int'(mem_busy), 0);
    chk("R1 outputs", int'({slew_mute, ramp_down_req, mem_we}), 0);

    // R2/R3: release core, then shut via active-high bit
    cyc(1, 16'h0200, 0);
    chk("R2 run released", int'(core_zero), 0);
    cyc(1, 16'h0240, 0);
    chk("R2 shut high", int'(core_zero), 1);
    cyc(1, 16'hFFFF & ~16'h0080, 0);
    chk("R3 all-ones readback", int'(rd_data), 16'h5240);

    // R4/R5/R6: clear walk with writes landing during it
    cyc(1, 16'h0280, 0);
    chk("R4 start addr", int'(mem_addr), 0);
    chk("R4 start busy", int'(rd_data[7]), 1);
    cyc(0, 16'h0, 0);
    cyc(1, 16'h0280, 0);
    chk("R6 restart ignored", int'(mem_addr), 2);
    cyc(1, 16'h0200, 0);
    chk("R6 abort ignored", int'(mem_busy), 1);
    for (int i = 0; i < DEPTH; i++) cyc(0, 16'h0, 0);
    chk("R5 walk ended", int'(mem_busy), 0);
    chk("R5 clear bit self-cleared", int'(rd_data[7]), 0);

    // R9/R10: ramp-down status
    cyc(1, 16'h2200, 0);
    chk("R10 write to done ignored", int'(rd_data[13]), 0);
    cyc(1, 16'h1200, 0);
    chk("R9 not yet at zero", int'(rd_data[13]), 0);
    cyc(0, 16'h0, 1);
    chk("R9 done set", int'(rd_data[13]), 1);
    cyc(0, 16'h0, 0);
    chk("R9 done sticky", int'(rd_data[13]), 1);
    cyc(1, 16'h0200, 1);
    chk("R10 done dropped with request", int'(rd_data[13]), 0);
    chk("R8 ramp up requested", int'(ramp_down_req), 0);
    cyc(1, 16'h4200, 0);
    chk("R7 mute set", int'(slew_mute), 1);
    cyc(1, 16'h0200, 0);
    chk("R7 mute cleared", int'(slew_mute), 0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 4) == 0;
      logic [15:0] wd = 16'($urandom);
      bit z = ($urandom % 3) == 0;
      if (($urandom % 4) != 0) wd[7] = 1'b0;
      cyc(we, wd, z);
    end
    finish_run();
  end
endmodule